// File: doc/BRIEF.md
# Decode Stage Skid-Buffer Flow Controller

This block is the flow-control core of a single-thread decode stage. Each cycle it receives a group of up to `FW` instruction slots from the fetch side and forwards up to `DW` of them to the rename side. Each instruction is an opaque tag with two flags: one marks it as squashed and one says it reads no source registers. When the rename, execute or commit stage asks for a stall, the block stops forwarding. It parks every arriving instruction in a circular skid buffer and sends one block pulse toward fetch.

When every stall has been withdrawn, the block passes through a draining phase. In that phase it issues from the skid buffer, oldest first, and appends any new arrivals behind the parked entries. Only when the buffer has run dry does it send an unblock pulse to fetch and resume forwarding directly. A squash from commit overrides everything else: it flushes the parked instructions and drops the arriving group. A reorder-buffer squash that is still in progress holds the stage silent. Two sticky flags report protocol faults: an unblock request that matched no active stall, and arrivals that did not fit in the skid buffer.

Top module: `dec_skid_ctrl`

## Requirements
- R1: Reset is synchronous and active high. After reset `state_o` reads 0 (Idle), all three stall latches are clear, and every output is zero. `state_o` uses this encoding: Idle=0, Running=1, Blocked=2, Unblocking=3, Squashing=4.
- R2: Each stall source has its own latch. The source's block input sets the latch and its unblock input clears it; unblock wins when both are high. An unblock while the latch is clear and the block input is low sets the sticky `err_unblock`.
- R3: When any latch is set after this cycle's update and no squash of either kind is present, the state becomes Blocked and all valid arrivals enter the skid buffer. `fetch_block` pulses only when the previous state was not Blocked.
- R4: A Blocked stage with no stall and no squash moves to Unblocking. It appends that cycle's arrivals to the skid buffer and forwards nothing.
- R5: In Unblocking, up to `DW` entries leave the skid head, oldest first, and the non-squashed ones are forwarded. Arrivals are then appended. If the buffer is then empty, `fetch_unblock` pulses and the state becomes Running.
- R6: In Idle, Running or Squashing, arrivals are examined in slot order. Valid non-squashed ones are forwarded until `DW` have been sent, and squashed ones are dropped without using an output slot.
- R7: Valid arrivals that are not examined because the `DW` limit was reached are moved to the skid buffer. The state becomes Blocked and `fetch_block` pulses.
- R8: `out_ready[j]` is high exactly when slot j is valid and carries an instruction with no source registers.
- R9: `cmt_squash` has top priority. It empties the skid buffer, drops the arrivals and forwards nothing, and the state becomes Squashing. `fetch_unblock` pulses if the previous state was Blocked or Unblocking.
- R10: `rob_squashing` without `cmt_squash` keeps or puts the state in Squashing. It forwards nothing and ranks above any stall.
- R11: A Squashing stage with no squash or stall returns to Running and forwards arrivals in the same cycle.
- R12: Skid capacity is `FQ_DELAY*FW+DW` entries. Arrivals beyond the free space, counted after this cycle's removals, are discarded and set the sticky `err_overflow`.
- R13: All outputs are registered one cycle after the inputs that cause them. Valid slots are packed from slot 0 upward, and `out_cnt` equals the number of valid slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | FW | Per-slot valid of the arriving group |
| in_tag | input | FW*TAG_W | Per-slot instruction tag |
| in_squashed | input | FW | Per-slot squashed mark |
| in_nosrc | input | FW | Per-slot no-source-register flag |
| ren_block | input | 1 | Rename stall request |
| ren_unblock | input | 1 | Rename stall release |
| exe_block | input | 1 | Execute stall request |
| exe_unblock | input | 1 | Execute stall release |
| cmt_block | input | 1 | Commit stall request |
| cmt_unblock | input | 1 | Commit stall release |
| cmt_squash | input | 1 | Squash from commit |
| rob_squashing | input | 1 | Reorder-buffer squash in progress |
| out_vld | output | DW | Valid of each forwarded slot |
| out_tag | output | DW*TAG_W | Tag of each forwarded slot |
| out_ready | output | DW | Slot is ready to issue (no sources) |
| out_cnt | output | clog2(DW+1) | Number of valid forwarded slots |
| fetch_block | output | 1 | One-cycle block pulse to fetch |
| fetch_unblock | output | 1 | One-cycle unblock pulse to fetch |
| state_o | output | 3 | Current status state |
| err_unblock | output | 1 | Sticky: release without a matching stall |
| err_overflow | output | 1 | Sticky: skid buffer overflow |

## Verification
The bench targets the following corner cases:
- A stall that is held for several cycles. A design that re-sent the block pulse on every cycle would flood fetch.
- A drain that leaves the buffer non-empty because new arrivals came in. Unblocking early would let new instructions overtake parked ones.
- A group whose squashed slot sits before the width limit. Letting that slot use an output position would send too few instructions.
- A squash while draining, which must both flush the buffer and release fetch.
- A run of blocked cycles long enough to overflow the buffer, and a release that matched no stall.

Both must raise their sticky flags without disturbing the rest of the flow.

// File: rtl/dec_pkg.sv
package dec_pkg;

    localparam int TAG_W = 8;

    typedef struct packed {
        logic             squashed;
        logic             no_src;
        logic [TAG_W-1:0] tag;
    } dinst_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RUN   = 3'd1,
        ST_BLK   = 3'd2,
        ST_UNBLK = 3'd3,
        ST_SQ    = 3'd4
    } dstate_e;

endpackage

// File: rtl/dec_stall_track.sv
module dec_stall_track #(
    parameter int NSRC = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] blk_i,
    input  logic [NSRC-1:0] unblk_i,
    output logic [NSRC-1:0] lat_nxt_o,
    output logic            err_o
);
    logic [NSRC-1:0] lat_q;
    logic [NSRC-1:0] bad;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        // release wins over a same-cycle request
        assign lat_nxt_o[g] = (lat_q[g] | blk_i[g]) & ~unblk_i[g];
        assign bad[g]       = unblk_i[g] & ~(lat_q[g] | blk_i[g]);

        AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (rst)
            unblk_i[g] |=> !lat_q[g]); // R2
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q <= '0;
            err_o <= 1'b0;
        end else begin
            lat_q <= lat_nxt_o;
            if (|bad) err_o <= 1'b1;
        end
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o); // R2

endmodule

// File: rtl/dec_issue_sel.sv
module dec_issue_sel
    import dec_pkg::*;
#(
    parameter int N = 4,
    parameter int W = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N-1:0]             cand_vld_i,
    input  dinst_t [N-1:0]           cand_i,
    output logic [N-1:0]             taken_o,
    output logic [W-1:0]             sel_vld_o,
    output dinst_t [W-1:0]           sel_o,
    output logic [$clog2(W+1)-1:0]   sel_cnt_o
);
    localparam int CW = $clog2(W + 1);

    always_comb begin
        int f;
        f         = 0;
        taken_o   = '0;
        sel_vld_o = '0;
        sel_o     = '0;
        for (int i = 0; i < N; i++) begin
            if (cand_vld_i[i] && (f < W)) begin
                taken_o[i] = 1'b1;
                if (!cand_i[i].squashed) begin
                    for (int j = 0; j < W; j++) begin
                        if (j == f) begin
                            sel_vld_o[j] = 1'b1;
                            sel_o[j]     = cand_i[i];
                        end
                    end
                    f = f + 1;
                end
            end
        end
        sel_cnt_o = CW'(f);
    end

    // a squashed candidate never reaches an output slot
    AST_NO_SQUASHED_OUT: assert property (@(posedge clk) disable iff (rst)
        (sel_o[0].squashed == 1'b0) || !sel_vld_o[0]); // R6

endmodule

// File: rtl/dec_skid_fifo.sv
module dec_skid_fifo
    import dec_pkg::*;
#(
    parameter int DEPTH = 10,
    parameter int PW    = 4,
    parameter int RW    = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         flush_i,
    input  logic [$clog2(PW+1)-1:0]      push_n_i,
    input  dinst_t [PW-1:0]              push_i,
    input  logic [$clog2(RW+1)-1:0]      pop_n_i,
    output logic [$clog2(DEPTH+1)-1:0]   cnt_o,
    output logic [RW-1:0]                win_vld_o,
    output dinst_t [RW-1:0]              win_o,
    output logic                         ovf_o
);
    localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW   = $clog2(DEPTH + 1);

    dinst_t          mem [DEPTH];
    logic [PTRW-1:0] head_q;
    logic [PTRW-1:0] tail_q;
    logic [CW-1:0]   cnt_q;
    int              after_pop;
    int              space;
    int              acc;
    logic            ovf_now;

    function automatic logic [PTRW-1:0] adv(input logic [PTRW-1:0] p, input int k);
        int s;
        s = int'(p) + k;
        if (s >= DEPTH) s = s - DEPTH;
        return PTRW'(s);
    endfunction

    always_comb begin
        after_pop = int'(cnt_q) - int'(pop_n_i);
        space     = DEPTH - after_pop;
        acc       = (int'(push_n_i) < space) ? int'(push_n_i) : space;
        ovf_now   = int'(push_n_i) > space;
    end

    always_comb begin
        for (int i = 0; i < RW; i++) begin
            win_o[i]     = mem[adv(head_q, i)];
            win_vld_o[i] = (i < int'(cnt_q));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && !flush_i) begin
            for (int i = 0; i < PW; i++) begin
                if (i < acc) mem[adv(tail_q, i)] <= push_i[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
            ovf_o  <= 1'b0;
        end else if (flush_i) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else begin
            head_q <= adv(head_q, int'(pop_n_i));
            tail_q <= adv(tail_q, acc);
            cnt_q  <= CW'(after_pop + acc);
            if (ovf_now) ovf_o <= 1'b1;
        end
    end

    assign cnt_o = cnt_q;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        int'(cnt_q) <= DEPTH); // R12
    AST_POP_WITHIN: assert property (@(posedge clk) disable iff (rst)
        int'(pop_n_i) <= int'(cnt_q)); // R5
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf_o |=> ovf_o); // R12

endmodule

// File: rtl/dec_skid_ctrl.sv
module dec_skid_ctrl
    import dec_pkg::*;
#(
    parameter int  FW       = 4,
    parameter int  DW       = 2,
    parameter int  FQ_DELAY = 2,
    localparam int OCW      = $clog2(DW + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [FW-1:0]             in_vld,
    input  logic [FW-1:0][TAG_W-1:0]  in_tag,
    input  logic [FW-1:0]             in_squashed,
    input  logic [FW-1:0]             in_nosrc,
    input  logic                      ren_block,
    input  logic                      ren_unblock,
    input  logic                      exe_block,
    input  logic                      exe_unblock,
    input  logic                      cmt_block,
    input  logic                      cmt_unblock,
    input  logic                      cmt_squash,
    input  logic                      rob_squashing,
    output logic [DW-1:0]             out_vld,
    output logic [DW-1:0][TAG_W-1:0]  out_tag,
    output logic [DW-1:0]             out_ready,
    output logic [OCW-1:0]            out_cnt,
    output logic                      fetch_block,
    output logic                      fetch_unblock,
    output logic [2:0]                state_o,
    output logic                      err_unblock,
    output logic                      err_overflow
);
    localparam int SKID_DEPTH = FQ_DELAY * FW + DW;
    localparam int PNW        = $clog2(FW + 1);
    localparam int RNW        = $clog2(DW + 1);
    localparam int CW         = $clog2(SKID_DEPTH + 1);

    dstate_e          st_q, st_n;
    logic [2:0]       lat_nxt;
    logic             any_stall;
    dinst_t [FW-1:0]  in_inst;

    // input-side selection
    logic [FW-1:0]    in_taken;
    logic [DW-1:0]    is_vld;
    dinst_t [DW-1:0]  is_slot;
    logic [OCW-1:0]   is_cnt;

    // skid-side selection
    logic [DW-1:0]    win_vld;
    dinst_t [DW-1:0]  win;
    logic [DW-1:0]    sk_taken;
    logic [DW-1:0]    ss_vld;
    dinst_t [DW-1:0]  ss_slot;
    logic [OCW-1:0]   ss_cnt;
    logic [RNW-1:0]   sk_pops;
    logic [CW-1:0]    sk_cnt;

    // control
    logic             fb_n, fu_n, flush, use_in, use_sk;
    logic [FW-1:0]    push_mask;
    logic [RNW-1:0]   pop_n;
    logic [PNW-1:0]   push_n;
    dinst_t [FW-1:0]  push_data;
    logic [DW-1:0]    ov_vld;
    dinst_t [DW-1:0]  ov_slot;
    logic [OCW-1:0]   ov_cnt;

    always_comb begin
        for (int i = 0; i < FW; i++) begin
            in_inst[i].squashed = in_squashed[i];
            in_inst[i].no_src   = in_nosrc[i];
            in_inst[i].tag      = in_tag[i];
        end
    end

    dec_stall_track #(.NSRC(3)) u_stall (
        .clk       (clk),
        .rst       (rst),
        .blk_i     ({cmt_block, exe_block, ren_block}),
        .unblk_i   ({cmt_unblock, exe_unblock, ren_unblock}),
        .lat_nxt_o (lat_nxt),
        .err_o     (err_unblock)
    );

    assign any_stall = |lat_nxt;

    dec_issue_sel #(.N(FW), .W(DW)) u_sel_in (
        .clk        (clk),
        .rst        (rst),
        .cand_vld_i (in_vld),
        .cand_i     (in_inst),
        .taken_o    (in_taken),
        .sel_vld_o  (is_vld),
        .sel_o      (is_slot),
        .sel_cnt_o  (is_cnt)
    );

    dec_issue_sel #(.N(DW), .W(DW)) u_sel_skid (
        .clk        (clk),
        .rst        (rst),
        .cand_vld_i (win_vld),
        .cand_i     (win),
        .taken_o    (sk_taken),
        .sel_vld_o  (ss_vld),
        .sel_o      (ss_slot),
        .sel_cnt_o  (ss_cnt)
    );

    always_comb begin
        sk_pops = '0;
        for (int j = 0; j < DW; j++) sk_pops = sk_pops + RNW'(sk_taken[j]);
    end

    // status machine, in priority order
    always_comb begin
        st_n      = st_q;
        fb_n      = 1'b0;
        fu_n      = 1'b0;
        flush     = 1'b0;
        push_mask = '0;
        pop_n     = '0;
        use_in    = 1'b0;
        use_sk    = 1'b0;
        if (cmt_squash) begin
            st_n  = ST_SQ;
            flush = 1'b1;
            fu_n  = (st_q == ST_BLK) || (st_q == ST_UNBLK);
        end else if (rob_squashing) begin
            st_n = ST_SQ;
        end else if (any_stall) begin
            push_mask = in_vld;
            fb_n      = (st_q != ST_BLK);
            st_n      = ST_BLK;
        end else if (st_q == ST_BLK) begin
            push_mask = in_vld;
            st_n      = ST_UNBLK;
        end else if (st_q == ST_UNBLK) begin
            use_sk    = 1'b1;
            pop_n     = sk_pops;
            push_mask = in_vld;
            if ((int'(sk_cnt) == int'(sk_pops)) && !(|in_vld)) begin
                fu_n = 1'b1;
                st_n = ST_RUN;
            end
        end else begin
            use_in    = 1'b1;
            push_mask = in_vld & ~in_taken;
            if (|(in_vld & ~in_taken)) begin
                fb_n = 1'b1;
                st_n = ST_BLK;
            end else if (st_q == ST_SQ) begin
                st_n = ST_RUN;
            end
        end
    end

    // pack selected arrivals into consecutive push lanes
    always_comb begin
        int k;
        k         = 0;
        push_data = '0;
        for (int i = 0; i < FW; i++) begin
            if (push_mask[i]) begin
                for (int j = 0; j < FW; j++) begin
                    if (j == k) push_data[j] = in_inst[i];
                end
                k = k + 1;
            end
        end
        push_n = PNW'(k);
    end

    dec_skid_fifo #(.DEPTH(SKID_DEPTH), .PW(FW), .RW(DW)) u_skid (
        .clk       (clk),
        .rst       (rst),
        .flush_i   (flush),
        .push_n_i  (push_n),
        .push_i    (push_data),
        .pop_n_i   (pop_n),
        .cnt_o     (sk_cnt),
        .win_vld_o (win_vld),
        .win_o     (win),
        .ovf_o     (err_overflow)
    );

    always_comb begin
        if (use_in) begin
            ov_vld  = is_vld;
            ov_slot = is_slot;
            ov_cnt  = is_cnt;
        end else if (use_sk) begin
            ov_vld  = ss_vld;
            ov_slot = ss_slot;
            ov_cnt  = ss_cnt;
        end else begin
            ov_vld  = '0;
            ov_slot = '0;
            ov_cnt  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q          <= ST_IDLE;
            fetch_block   <= 1'b0;
            fetch_unblock <= 1'b0;
            out_vld       <= '0;
            out_tag       <= '0;
            out_ready     <= '0;
            out_cnt       <= '0;
        end else begin
            st_q          <= st_n;
            fetch_block   <= fb_n;
            fetch_unblock <= fu_n;
            out_vld       <= ov_vld;
            out_cnt       <= ov_cnt;
            for (int j = 0; j < DW; j++) begin
                out_tag[j]   <= ov_slot[j].tag;
                out_ready[j] <= ov_vld[j] & ov_slot[j].no_src;
            end
        end
    end

    assign state_o = st_q;

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(fetch_block && fetch_unblock)); // R3
    AST_BLOCK_ON_ENTRY: assert property (@(posedge clk) disable iff (rst)
        fetch_block |-> (st_q == ST_BLK) && ($past(st_q) != ST_BLK)); // R3
    AST_SQ_SILENT: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SQ) |-> (out_cnt == '0)); // R9
    AST_UNBLK_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (fetch_unblock && (st_q == ST_RUN)) |-> (sk_cnt == '0)); // R5
    AST_CNT_MATCH: assert property (@(posedge clk) disable iff (rst)
        int'(out_cnt) == $countones(out_vld)); // R13
    AST_READY_QUAL: assert property (@(posedge clk) disable iff (rst)
        (out_ready & ~out_vld) == '0); // R8

endmodule

// File: tb/dec_skid_ctrl_tb.sv
module dec_skid_ctrl_tb;
    import dec_pkg::*;

    localparam int FW  = 4;
    localparam int DW  = 2;
    localparam int FQD = 2;
    localparam int CAP = FQD * FW + DW;
    localparam int OCW = $clog2(DW + 1);

    typedef struct {
        bit       sq;
        bit       ns;
        bit [7:0] tag;
    } m_inst_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [FW-1:0]            in_vld = '0;
    logic [FW-1:0][TAG_W-1:0] in_tag = '0;
    logic [FW-1:0]            in_squashed = '0;
    logic [FW-1:0]            in_nosrc = '0;
    logic [2:0]               blk_v = '0;
    logic [2:0]               ublk_v = '0;
    logic                     cmt_squash = 1'b0;
    logic                     rob_squashing = 1'b0;
    logic [DW-1:0]            out_vld;
    logic [DW-1:0][TAG_W-1:0] out_tag;
    logic [DW-1:0]            out_ready;
    logic [OCW-1:0]           out_cnt;
    logic                     fetch_block, fetch_unblock;
    logic [2:0]               state_o;
    logic                     err_unblock, err_overflow;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;

    // reference model state
    m_inst_t skq[$];
    int      m_st = 0;
    bit      m_lat[3];
    bit      m_eu = 0;
    bit      m_eo = 0;
    int      e_cnt = 0;
    bit      e_vld[DW];
    bit [7:0] e_tag[DW];
    bit      e_rdy[DW];
    bit      e_fb = 0;
    bit      e_fu = 0;
    string   e_req = "R1";

    always #10 clk = ~clk;

    dec_skid_ctrl #(.FW(FW), .DW(DW), .FQ_DELAY(FQD)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .in_vld        (in_vld),
        .in_tag        (in_tag),
        .in_squashed   (in_squashed),
        .in_nosrc      (in_nosrc),
        .ren_block     (blk_v[0]),
        .ren_unblock   (ublk_v[0]),
        .exe_block     (blk_v[1]),
        .exe_unblock   (ublk_v[1]),
        .cmt_block     (blk_v[2]),
        .cmt_unblock   (ublk_v[2]),
        .cmt_squash    (cmt_squash),
        .rob_squashing (rob_squashing),
        .out_vld       (out_vld),
        .out_tag       (out_tag),
        .out_ready     (out_ready),
        .out_cnt       (out_cnt),
        .fetch_block   (fetch_block),
        .fetch_unblock (fetch_unblock),
        .state_o       (state_o),
        .err_unblock   (err_unblock),
        .err_overflow  (err_overflow)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic m_push(input m_inst_t x);
        if (skq.size() < CAP) skq.push_back(x);
        else m_eo = 1'b1;
    endtask

    task automatic m_emit(input m_inst_t x);
        e_vld[e_cnt] = 1'b1;
        e_tag[e_cnt] = x.tag;
        e_rdy[e_cnt] = x.ns;
        e_cnt++;
    endtask

    task automatic model_step();
        m_inst_t ins[$];
        m_inst_t lft[$];
        bit any;
        for (int i = 0; i < FW; i++)
            if (in_vld[i]) ins.push_back('{in_squashed[i], in_nosrc[i], in_tag[i]});
        e_cnt = 0;
        e_fb  = 0;
        e_fu  = 0;
        for (int j = 0; j < DW; j++) begin
            e_vld[j] = 0; e_tag[j] = 0; e_rdy[j] = 0;
        end
        any = 0;
        for (int k = 0; k < 3; k++) begin
            if (ublk_v[k] && !(m_lat[k] || blk_v[k])) m_eu = 1'b1;
            m_lat[k] = (m_lat[k] || blk_v[k]) && !ublk_v[k];
            any = any | m_lat[k];
        end
        if (cmt_squash) begin
            e_req = "R9";
            e_fu  = (m_st == 2) || (m_st == 3);
            m_st  = 4;
            skq.delete();
        end else if (rob_squashing) begin
            e_req = "R10";
            m_st  = 4;
        end else if (any) begin
            e_req = "R3";
            e_fb  = (m_st != 2);
            m_st  = 2;
            foreach (ins[i]) m_push(ins[i]);
        end else if (m_st == 2) begin
            e_req = "R4";
            m_st  = 3;
            foreach (ins[i]) m_push(ins[i]);
        end else if (m_st == 3) begin
            e_req = "R5";
            for (int k = 0; k < DW; k++) begin
                if (skq.size() > 0) begin
                    m_inst_t x;
                    x = skq.pop_front();
                    if (!x.sq) m_emit(x);
                end
            end
            foreach (ins[i]) m_push(ins[i]);
            if (skq.size() == 0) begin
                e_fu = 1'b1;
                m_st = 1;
            end
        end else begin
            e_req = (m_st == 4) ? "R11" : "R6";
            foreach (ins[i]) begin
                if (e_cnt < DW) begin
                    if (!ins[i].sq) m_emit(ins[i]);
                end else begin
                    lft.push_back(ins[i]);
                end
            end
            if (lft.size() > 0) begin
                e_req = "R7";
                foreach (lft[i]) m_push(lft[i]);
                e_fb = 1'b1;
                m_st = 2;
            end else if (m_st == 4) begin
                m_st = 1;
            end
        end
    endtask

    task automatic compare();
        chk(int'(state_o) == m_st, e_req, "state", int'(state_o), m_st);
        chk(int'(out_cnt) == e_cnt, "R13", "out_cnt", int'(out_cnt), e_cnt);
        for (int j = 0; j < DW; j++) begin
            chk(out_vld[j] == e_vld[j], e_req, "out_vld", int'(out_vld[j]), int'(e_vld[j]));
            if (e_vld[j])
                chk(out_tag[j] == e_tag[j], e_req, "out_tag", int'(out_tag[j]), int'(e_tag[j]));
            chk(out_ready[j] == e_rdy[j], "R8", "out_ready", int'(out_ready[j]), int'(e_rdy[j]));
        end
        chk(fetch_block == e_fb, e_req, "fetch_block", int'(fetch_block), int'(e_fb));
        chk(fetch_unblock == e_fu, e_req, "fetch_unblock", int'(fetch_unblock), int'(e_fu));
        chk(err_unblock == m_eu, "R2", "err_unblock", int'(err_unblock), int'(m_eu));
        chk(err_overflow == m_eo, "R12", "err_overflow", int'(err_overflow), int'(m_eo));
    endtask

    task automatic clear_in();
        in_vld = '0; in_tag = '0; in_squashed = '0; in_nosrc = '0;
        blk_v = '0; ublk_v = '0; cmt_squash = 1'b0; rob_squashing = 1'b0;
    endtask

    task automatic fill(input int n, input bit [7:0] base);
        for (int i = 0; i < FW; i++) begin
            in_vld[i] = (i < n);
            in_tag[i] = base + 8'(i);
        end
    endtask

    task automatic step();
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic rand_in();
        clear_in();
        for (int i = 0; i < FW; i++) begin
            in_vld[i]      = ($urandom % 4) != 0;
            in_squashed[i] = ($urandom % 5) == 0;
            in_nosrc[i]    = ($urandom % 3) == 0;
            in_tag[i]      = 8'($urandom);
        end
        for (int k = 0; k < 3; k++) begin
            if (m_lat[k]) ublk_v[k] = ($urandom % 4) == 0;
            else          blk_v[k]  = ($urandom % 10) == 0;
        end
        cmt_squash    = ($urandom % 40) == 0;
        rob_squashing = ($urandom % 25) == 0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int seed_init;
        seed_init = $urandom(32'h00C0FFEE);
        for (int k = 0; k < 3; k++) m_lat[k] = 0;
        for (int j = 0; j < DW; j++) begin
            e_vld[j] = 0; e_tag[j] = 0; e_rdy[j] = 0;
        end
        clear_in();
        repeat (3) @(negedge clk);
        e_req = "R1";
        compare();   // R1 reset state
        rst = 1'b0;

        // R7 / R8: squashed slot 1 skipped, width limit leaves slot 3
        clear_in(); fill(4, 8'h10); in_squashed[1] = 1'b1; in_nosrc[0] = 1'b1;
        step();
        clear_in(); step();          // R4
        step();                      // R5 drains and releases
        // R3: held stall, single block pulse
        clear_in(); blk_v[0] = 1'b1; fill(2, 8'h20); step();
        clear_in(); fill(3, 8'h30); step();
        clear_in(); ublk_v[0] = 1'b1; step();
        clear_in(); repeat (4) step();
        // R12: overflow while stalled, then R9 squash during drain
        clear_in(); blk_v[1] = 1'b1; fill(4, 8'h40); step();
        clear_in(); fill(4, 8'h50); step();
        clear_in(); fill(4, 8'h60); step();
        clear_in(); ublk_v[1] = 1'b1; step();
        clear_in(); step();
        clear_in(); cmt_squash = 1'b1; fill(2, 8'h70); step();
        // R10 then R11
        clear_in(); rob_squashing = 1'b1; blk_v[2] = 1'b1; step();
        clear_in(); ublk_v[2] = 1'b1; rob_squashing = 1'b1; step();
        clear_in(); fill(2, 8'h80); step();
        // R2: release with no stall present
        clear_in(); ublk_v[2] = 1'b1; step();
        clear_in(); step();

        for (int n = 0; n < 3000; n++) begin
            rand_in();
            step();
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule